// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block picks the post-divider, feedback and reference-divider values for a pixel clock synthesizer. A requester presents a target pixel frequency in kHz and pulses start. The engine then walks every legal combination of post-divider P, feedback multiplier N and input divider M against a fixed 50000 kHz reference. It keeps the combination whose integer output frequency lies nearest the target. When the walk ends it pulses done and holds the chosen values and the remaining absolute error.

One candidate is scored per clock. A post-divider value is used only when target times P falls inside a fixed oscillator window. A rejected P costs one clock, so the search time follows from the target alone. The secondary divider S is always reported as zero. If no post-divider passes the window, the engine still completes and returns zero dividers with an all-ones error. The requester treats that as "no solution".

Top module: `pll_div_search`

## Requirements
- R1: After reset, done_o is 0, err_o is all ones, and pdiv_o, ndiv_o, mdiv_o and sdiv_o are all zero.
- R2: A post-divider value P is searched only when target×P lies between 150000 and 550000 inclusive. A rejected P costs one clock and contributes no candidate.
- R3: The walk takes P from 16 down to 1. For each accepted P it steps N from 1 to 256 in the outer loop and M from 1 to 16 in the inner loop, at one candidate per clock. done_o is high in the cycle after the (4096·A + (16−A) + 1)-th rising edge following the edge that accepted start, where A is the number of accepted P values.
- R4: A candidate's frequency is floor(50000·N / (M·P)) and its error is the absolute difference from the target. The reported triple has the smallest error of all candidates searched, and err_o holds that error.
- R5: A candidate replaces the held best only if its error is strictly smaller, so among equal errors the one met first in the walk order of R3 is reported.
- R6: sdiv_o is always 0.
- R7: If no P is accepted, done_o still pulses, with pdiv_o, ndiv_o and mdiv_o zero and err_o all ones.
- R8: The target is captured when start is accepted. start_i and target_i have no effect while a search is running.
- R9: done_o is a single-cycle pulse. The result outputs keep their values from the done pulse until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a search; sampled only when idle |
| target_i | input | 32 | Requested pixel frequency in kHz |
| done_o | output | 1 | One-cycle pulse when the search ends |
| pdiv_o | output | 5 | Chosen post-divider P |
| ndiv_o | output | 9 | Chosen feedback multiplier N |
| mdiv_o | output | 5 | Chosen input divider M |
| sdiv_o | output | 3 | Secondary divider, always zero |
| err_o | output | 32 | Absolute error of the chosen triple in kHz |

## Verification
The hardest situations to reach from the ports are the window edges and the tie between equal-error candidates. Targets are chosen so that target×P lands exactly on 150000 or on 550000. Other targets reject every P, including the all-ones value whose product would overflow a narrow multiplier. The target 150000 is met exactly by several triples, so any departure from first-found tie-breaking changes the reported N and M. A second start with a different target is injected in the middle of a long search, and the final result must match the first target only.

// File: rtl/pll_div_search_pkg.sv
// Shared types for the pixel clock divider search engine.
// Assumes: nothing beyond IEEE 1800-2017.
package pll_div_search_pkg;

    // Sequencer state: idle, walking candidates, draining the score stage.
    typedef enum logic [1:0] {
        SRCH_IDLE  = 2'd0,
        SRCH_SCAN  = 2'd1,
        SRCH_FLUSH = 2'd2
    } srch_state_t;

    // Width of the secondary divider output, which is held at zero.
    localparam int SDIV_W = 3;

endpackage

// File: rtl/pll_div_search_div.sv
// Unrolled restoring divider: quo_o = num_i / den_i, truncated.
// Assumes den_i is non-zero and below 2**DEN_W; the remainder is not needed.
// Each generate stage resolves one quotient bit, most significant first.
module pll_div_search_div #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 9
) (
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [NUM_W-1:0] quo_o
);

    // Partial remainder entering each stage.
    logic [DEN_W-1:0] rem_s [NUM_W];

    assign rem_s[0] = '0;

    for (genvar k = 0; k < NUM_W; k++) begin : g_stage
        logic [DEN_W:0] trial;
        assign trial = {rem_s[k], num_i[NUM_W-1-k]};
        if (k < NUM_W - 1) begin : g_mid
            logic [DEN_W:0] diff;
            // Borrow bit of the trial subtraction decides the quotient bit.
            assign diff = trial - {1'b0, den_i};
            assign quo_o[NUM_W-1-k] = ~diff[DEN_W];
            assign rem_s[k+1] = diff[DEN_W] ? trial[DEN_W-1:0] : diff[DEN_W-1:0];
        end else begin : g_last
            assign quo_o[0] = (trial >= {1'b0, den_i});
        end
    end

endmodule

// File: rtl/pll_div_search_scan.sv
// Candidate sequencer: latches the target on start, walks P downward and,
// for each P inside the oscillator window, N then M upward, one per clock.
// Assumes: start_i is ignored unless idle; one flush cycle follows the walk.
module pll_div_search_scan
    import pll_div_search_pkg::*;
#(
    parameter int TGT_W       = 32,
    parameter int P_MAX       = 16,
    parameter int N_MAX       = 256,
    parameter int M_MAX       = 16,
    parameter int VCO_MIN_KHZ = 150000,
    parameter int VCO_MAX_KHZ = 550000,
    localparam int PW = $clog2(P_MAX + 1),
    localparam int NW = $clog2(N_MAX + 1),
    localparam int MW = $clog2(M_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [TGT_W-1:0] target_i,
    output logic             init_o,
    output logic             cand_vld_o,
    output logic [PW-1:0]    cand_p_o,
    output logic [NW-1:0]    cand_n_o,
    output logic [MW-1:0]    cand_m_o,
    output logic [TGT_W-1:0] tgt_o,
    output logic             flush_o
);

    localparam int VW = TGT_W + PW;

    srch_state_t      state_q;
    logic [PW-1:0]    p_q;
    logic [NW-1:0]    n_q;
    logic [MW-1:0]    m_q;
    logic [TGT_W-1:0] tgt_q;
    logic [VW-1:0]    vco;
    logic             win;
    logic             m_last;
    logic             n_last;
    logic             p_end;

    // Oscillator window test for the current post-divider, full width.
    always_comb begin
        vco    = VW'(tgt_q) * VW'(p_q);
        win    = (vco >= VW'(VCO_MIN_KHZ)) && (vco <= VW'(VCO_MAX_KHZ));
        m_last = (m_q == MW'(M_MAX));
        n_last = (n_q == NW'(N_MAX));
        p_end  = !win || (m_last && n_last);
    end

    // Sequencer: capture target, step counters, leave after P reaches one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRCH_IDLE;
            p_q     <= '0;
            n_q     <= '0;
            m_q     <= '0;
            tgt_q   <= '0;
        end else begin
            case (state_q)
                SRCH_IDLE: begin
                    if (start_i) begin
                        tgt_q   <= target_i;
                        p_q     <= PW'(P_MAX);
                        n_q     <= NW'(1);
                        m_q     <= MW'(1);
                        state_q <= SRCH_SCAN;
                    end
                end
                SRCH_SCAN: begin
                    if (p_end) begin
                        n_q <= NW'(1);
                        m_q <= MW'(1);
                        if (p_q == PW'(1)) begin
                            state_q <= SRCH_FLUSH;
                        end else begin
                            p_q <= p_q - 1'b1;
                        end
                    end else if (m_last) begin
                        m_q <= MW'(1);
                        n_q <= n_q + 1'b1;
                    end else begin
                        m_q <= m_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= SRCH_IDLE;
                end
            endcase
        end
    end

    assign init_o     = (state_q == SRCH_IDLE) && start_i;
    assign cand_vld_o = (state_q == SRCH_SCAN) && win;
    assign cand_p_o   = p_q;
    assign cand_n_o   = n_q;
    assign cand_m_o   = m_q;
    assign tgt_o      = tgt_q;
    assign flush_o    = (state_q == SRCH_FLUSH);

    // R3: every issued candidate lies inside the legal counter ranges.
    a_r3_cand_range: assert property (@(posedge clk) disable iff (!rst_n)
        cand_vld_o |-> (p_q != '0) && (n_q != '0) && (m_q != '0)
                       && (n_q <= NW'(N_MAX)) && (m_q <= MW'(M_MAX)));

    // R3: consecutive candidates inside one N step advance M by one.
    a_r3_m_step: assert property (@(posedge clk) disable iff (!rst_n)
        cand_vld_o && $past(cand_vld_o) && ($past(m_q) != MW'(M_MAX))
        |-> m_q == $past(m_q) + 1'b1);

    // R8: the captured target does not move while a search is running.
    a_r8_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SRCH_IDLE) && $past(state_q != SRCH_IDLE) |-> $stable(tgt_q));

endmodule

// File: rtl/pll_div_search_best.sv
// Score stage and best-candidate keeper: registers one scored candidate,
// then replaces the held best only on a strictly smaller error.
// Assumes init_i and cand_vld_i never coincide with a valid staged score.
module pll_div_search_best #(
    parameter int EW = 32,
    parameter int PW = 5,
    parameter int NW = 9,
    parameter int MW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          flush_i,
    input  logic          cand_vld_i,
    input  logic [EW-1:0] cand_err_i,
    input  logic [PW-1:0] cand_p_i,
    input  logic [NW-1:0] cand_n_i,
    input  logic [MW-1:0] cand_m_i,
    output logic          done_o,
    output logic [EW-1:0] best_err_o,
    output logic [PW-1:0] best_p_o,
    output logic [NW-1:0] best_n_o,
    output logic [MW-1:0] best_m_o
);

    logic          st_vld_q;
    logic [EW-1:0] st_err_q;
    logic [PW-1:0] st_p_q;
    logic [NW-1:0] st_n_q;
    logic [MW-1:0] st_m_q;
    logic [EW-1:0] best_err_q;
    logic [PW-1:0] best_p_q;
    logic [NW-1:0] best_n_q;
    logic [MW-1:0] best_m_q;
    logic          done_q;

    // Score register between the divider and the comparator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_vld_q <= 1'b0;
            st_err_q <= '0;
            st_p_q   <= '0;
            st_n_q   <= '0;
            st_m_q   <= '0;
        end else begin
            st_vld_q <= cand_vld_i;
            st_err_q <= cand_err_i;
            st_p_q   <= cand_p_i;
            st_n_q   <= cand_n_i;
            st_m_q   <= cand_m_i;
        end
    end

    // Best keeper: clear on start, take strictly better staged scores.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) begin
            best_err_q <= '1;
            best_p_q   <= '0;
            best_n_q   <= '0;
            best_m_q   <= '0;
        end else if (st_vld_q && (st_err_q < best_err_q)) begin
            best_err_q <= st_err_q;
            best_p_q   <= st_p_q;
            best_n_q   <= st_n_q;
            best_m_q   <= st_m_q;
        end
    end

    // Done pulse follows the flush cycle, when the last score has landed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= flush_i;
        end
    end

    assign done_o     = done_q;
    assign best_err_o = best_err_q;
    assign best_p_o   = best_p_q;
    assign best_n_o   = best_n_q;
    assign best_m_o   = best_m_q;

    // R9: done never stays high for two cycles.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R9: with no staged score and no start, the held result is unchanged.
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !st_vld_q && !init_i |=> $stable(best_err_q) && $stable(best_p_q)
                                 && $stable(best_n_q) && $stable(best_m_q));

    // R4: without a restart the held error can only shrink.
    a_r4_err_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> best_err_q <= $past(best_err_q));

    // R7: an all-ones error at done means no divider was ever chosen.
    a_r7_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && (&best_err_q) |-> (best_p_q == '0) && (best_n_q == '0)
                                    && (best_m_q == '0));

endmodule

// File: rtl/pll_div_search.sv
// Top of the pixel clock divider search engine. Joins the sequencer, the
// unrolled divider with the error computation, and the best-candidate keeper.
// Assumes a fixed reference frequency and M_MAX*P_MAX below 2**DEN_W.
module pll_div_search
    import pll_div_search_pkg::*;
#(
    parameter int REF_KHZ     = 50000,
    parameter int VCO_MIN_KHZ = 150000,
    parameter int VCO_MAX_KHZ = 550000,
    parameter int P_MAX       = 16,
    parameter int N_MAX       = 256,
    parameter int M_MAX       = 16,
    parameter int TGT_W       = 32,
    parameter int NUM_W       = 32,
    localparam int PW    = $clog2(P_MAX + 1),
    localparam int NW    = $clog2(N_MAX + 1),
    localparam int MW    = $clog2(M_MAX + 1),
    localparam int DEN_W = $clog2(M_MAX * P_MAX + 1),
    localparam int EW    = (NUM_W > TGT_W) ? NUM_W : TGT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TGT_W-1:0]  target_i,
    output logic              done_o,
    output logic [PW-1:0]     pdiv_o,
    output logic [NW-1:0]     ndiv_o,
    output logic [MW-1:0]     mdiv_o,
    output logic [SDIV_W-1:0] sdiv_o,
    output logic [EW-1:0]     err_o
);

    logic             init;
    logic             cand_vld;
    logic [PW-1:0]    cand_p;
    logic [NW-1:0]    cand_n;
    logic [MW-1:0]    cand_m;
    logic [TGT_W-1:0] tgt;
    logic             flush;
    logic [NUM_W-1:0] num;
    logic [DEN_W-1:0] den;
    logic [NUM_W-1:0] quo;
    logic [EW-1:0]    freq_x;
    logic [EW-1:0]    tgt_x;
    logic [EW-1:0]    cand_err;

    pll_div_search_scan #(
        .TGT_W       (TGT_W),
        .P_MAX       (P_MAX),
        .N_MAX       (N_MAX),
        .M_MAX       (M_MAX),
        .VCO_MIN_KHZ (VCO_MIN_KHZ),
        .VCO_MAX_KHZ (VCO_MAX_KHZ)
    ) scan_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .target_i   (target_i),
        .init_o     (init),
        .cand_vld_o (cand_vld),
        .cand_p_o   (cand_p),
        .cand_n_o   (cand_n),
        .cand_m_o   (cand_m),
        .tgt_o      (tgt),
        .flush_o    (flush)
    );

    // Numerator and denominator of the candidate frequency.
    always_comb begin
        num = NUM_W'(REF_KHZ) * NUM_W'(cand_n);
        den = DEN_W'(cand_m) * DEN_W'(cand_p);
    end

    pll_div_search_div #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) div_i (
        .num_i (num),
        .den_i (den),
        .quo_o (quo)
    );

    // Absolute distance between candidate frequency and target.
    always_comb begin
        freq_x   = EW'(quo);
        tgt_x    = EW'(tgt);
        cand_err = (freq_x > tgt_x) ? (freq_x - tgt_x) : (tgt_x - freq_x);
    end

    pll_div_search_best #(
        .EW (EW),
        .PW (PW),
        .NW (NW),
        .MW (MW)
    ) best_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init),
        .flush_i    (flush),
        .cand_vld_i (cand_vld),
        .cand_err_i (cand_err),
        .cand_p_i   (cand_p),
        .cand_n_i   (cand_n),
        .cand_m_i   (cand_m),
        .done_o     (done_o),
        .best_err_o (err_o),
        .best_p_o   (pdiv_o),
        .best_n_o   (ndiv_o),
        .best_m_o   (mdiv_o)
    );

    assign sdiv_o = '0;

    // R2: a scored candidate always belongs to a P inside the window.
    a_r2_window_only: assert property (@(posedge clk) disable iff (!rst_n)
        cand_vld |-> ({5'd0, tgt} * {{TGT_W{1'b0}}, cand_p}) >= (TGT_W + 5 + PW)'(VCO_MIN_KHZ));

endmodule

// File: tb/pll_div_search_tb.sv
// Bench for the pixel clock divider search engine: a behavioural model
// predicts the done cycle and the result and is compared on every clock.
module pll_div_search_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] target_i = '0;
    logic        done_o;
    logic [4:0]  pdiv_o;
    logic [8:0]  ndiv_o;
    logic [4:0]  mdiv_o;
    logic [2:0]  sdiv_o;
    logic [31:0] err_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pll_div_search dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .target_i (target_i),
        .done_o   (done_o),
        .pdiv_o   (pdiv_o),
        .ndiv_o   (ndiv_o),
        .mdiv_o   (mdiv_o),
        .sdiv_o   (sdiv_o),
        .err_o    (err_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference search: returns the cycle count and the expected result.
    task automatic ref_search(input longint t, output longint k, output longint rp,
                              output longint rn, output longint rm, output longint re);
        longint acc = 0;
        re = 64'hFFFF_FFFF; rp = 0; rn = 0; rm = 0;
        for (int p = 16; p >= 1; p--) begin
            if (t * p > 550000 || t * p < 150000) continue;
            acc++;
            for (int n = 1; n <= 256; n++) begin
                for (int m = 1; m <= 16; m++) begin
                    longint f = (longint'(50000) * n) / (m * p);
                    longint e = (f > t) ? f - t : t - f;
                    if (e < re) begin re = e; rp = p; rn = n; rm = m; end
                end
            end
        end
        k = 4096 * acc + (16 - acc);
    endtask

    // Inputs sampled at the rising edge, as the design sees them.
    logic   smp_rst = 1'b0;
    logic   smp_start = 1'b0;
    logic [31:0] smp_tgt = '0;
    always @(posedge clk) begin
        smp_rst   <= rst_n;
        smp_start <= start_i;
        smp_tgt   <= target_i;
    end

    // Behavioural model, evaluated between edges.
    bit     mdl_busy = 1'b0;
    bit     exp_done = 1'b0;
    bit     vals_ok = 1'b0;
    longint remain = 0;
    longint pend_p, pend_n, pend_m, pend_e, pend_k;
    longint exp_p = 0, exp_n = 0, exp_m = 0, exp_e = 64'hFFFF_FFFF;

    always @(negedge clk) begin
        exp_done = 1'b0;
        if (!smp_rst) begin
            mdl_busy = 1'b0;
            vals_ok  = 1'b1;
            exp_p = 0; exp_n = 0; exp_m = 0; exp_e = 64'hFFFF_FFFF;
        end else if (!mdl_busy && smp_start) begin
            ref_search(longint'(smp_tgt), pend_k, pend_p, pend_n, pend_m, pend_e);
            mdl_busy = 1'b1;
            vals_ok  = 1'b0;
            remain   = pend_k + 1;
        end else if (mdl_busy) begin
            remain--;
            if (remain == 0) begin
                mdl_busy = 1'b0;
                exp_done = 1'b1;
                vals_ok  = 1'b1;
                exp_p = pend_p; exp_n = pend_n; exp_m = pend_m; exp_e = pend_e;
            end
        end
        if (smp_rst) begin
            // R3 R9: done only in the predicted cycle, for one cycle.
            chk("R3/R9 done timing", longint'(done_o), longint'(exp_done));
            // R6: secondary divider is zero at all times.
            chk("R6 sdiv", longint'(sdiv_o), 0);
            if (vals_ok) begin
                // R4 R5 R7 R8 R9: held result equals the model's best.
                chk("R4/R5 pdiv", longint'(pdiv_o), exp_p);
                chk("R4/R5 ndiv", longint'(ndiv_o), exp_n);
                chk("R4/R5 mdiv", longint'(mdiv_o), exp_m);
                chk("R4/R7 err", longint'(err_o), exp_e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=<200000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_idle();
        repeat (3) @(posedge clk);
        while (mdl_busy) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    task automatic run(input logic [31:0] t);
        @(negedge clk);
        target_i = t;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset values, checked by the model while reset holds and after.
        chk("R1 reset done", longint'(done_o), 0);
        chk("R1 reset err", longint'(err_o), 64'hFFFF_FFFF);
        chk("R1 reset pdiv", longint'(pdiv_o), 0);
        chk("R1 reset ndiv", longint'(ndiv_o), 0);
        chk("R1 reset mdiv", longint'(mdiv_o), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8: a second start and a new target mid-search are ignored.
        @(negedge clk);
        target_i = 32'd10000;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        repeat (2000) @(negedge clk);
        target_i = 32'd150000;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        wait_idle();

        run(32'd100000);      // R2 R4: four accepted P values
        run(32'd148000);      // R2: P=1 just below the window
        run(32'd550000);      // R2: upper window edge on P=1
        run(32'd150000);      // R2 R5: lower edge, several exact matches
        run(32'd600000);      // R7: no P accepted
        run(32'hFFFF_FFFF);   // R7: product far beyond the window
        run(32'd0);           // R7: product below the window

        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule